// File: doc/BRIEF.md
# Dual-Line Four-Channel Serial Audio Receiver

This block takes a standard I2S stream that has been widened to two data lines. A single bit clock and a single word-select line are shared by both lines. One line carries the front left and right channels, and the other carries the rear left and right channels. Both lines are shifted in on the same bit-clock edges. Each completed frame produces one aligned set of four signed 18-bit words.

The deserializer runs on the serial bit clock. When a frame is complete, the set is parked in a holding register and a toggle is flipped. A synchronizer on the system clock detects the toggle, copies all four words at once and raises a single-cycle strobe. Downstream logic on the system clock therefore sees four words that always belong to the same audio sample.

Top module: `i2s4_rx`

## Requirements
- R1: A word sent while word-select is low (0) is a left-channel word, and a word sent while word-select is high (1) is a right-channel word.
- R2: The front data line feeds `word_fl`/`word_fr`, and the rear data line feeds `word_rl`/`word_rr`.
- R3: Data is sampled on rising bit-clock edges, MSB first, in two's complement. The MSB is the bit sampled on the second rising edge after word-select changes. The bit sampled on the first rising edge after the change is the last bit of the previous word.
- R4: When a channel slot holds more than 18 bits, only the first 18 bits after the MSB position are kept, and the surplus bits have no effect on the output.
- R5: When a channel slot holds fewer than 18 bits, the bits received fill the top of the word and the missing low bits read as zero.
- R6: All four output words change in the same system-clock cycle. In that cycle `word_valid` is high for exactly one cycle. This happens once per frame, after the right word has been closed by word-select returning low. The left words are held until then.
- R7: While reset is asserted, and after it, all four words read zero and `word_valid` stays low. No strobe is raised until a complete left word followed by a complete right word has been received. A left word already in progress when reset is released is discarded.
- R8: Between strobes the four output words keep their values, including when the serial stream is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_sys | input | 1 | System clock for the output side |
| rst_n | input | 1 | Asynchronous active-low reset, both clock domains |
| sck | input | 1 | Continuous serial bit clock |
| ws | input | 1 | Word select: 0 left, 1 right |
| sd_front | input | 1 | Serial data, front pair |
| sd_rear | input | 1 | Serial data, rear pair |
| word_valid | output | 1 | One-cycle strobe when a new sample set is presented |
| word_fl | output | 18 | Front left word, signed |
| word_fr | output | 18 | Front right word, signed |
| word_rl | output | 18 | Rear left word, signed |
| word_rr | output | 18 | Rear right word, signed |

## Verification
The assertions rely on the bit clock being continuous and on frames being much longer than the synchronizer delay. A new set is therefore never parked in the holding register while the previous toggle is still crossing into the system domain. The stimulus keeps the bit clock at eight system-clock periods and uses channel slots of at least 12 bits. Word-select and data change only on falling bit-clock edges. Frames are sent back to back so that every right word is closed by the next word-select fall. Reset is always applied with both clocks running.

// File: rtl/i2s4_pkg.sv
`timescale 1ns/1ps
package i2s4_pkg;
    localparam int SAMPLE_W = 18;
    localparam int SYNC_N   = 2;

    typedef enum logic {
        SIDE_LEFT  = 1'b0,
        SIDE_RIGHT = 1'b1
    } side_e;
endpackage

// File: rtl/i2s4_lane.sv
`timescale 1ns/1ps
// One serial data line: assembles the word currently being received, MSB first.
module i2s4_lane #(
    parameter int W  = 18,
    parameter int CW = 5
) (
    input  logic          sck,
    input  logic          rst_n,
    input  logic          sd,
    input  logic          close_i,
    input  logic [CW-1:0] cnt_i,
    output logic [W-1:0]  word_o
);
    typedef struct packed {
        logic [W-1:0] sh;
    } lane_t;

    lane_t st_d, st_q;

    always_comb begin
        word_o = st_q.sh;
        for (int i = 0; i < W; i++) begin
            if (cnt_i == CW'(W - 1 - i)) word_o[i] = sd;
        end
        st_d.sh = close_i ? '0 : word_o;
    end

    always_ff @(posedge sck or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/i2s4_ctrl.sv
`timescale 1ns/1ps
// Word-select tracking, bit position counter and frame completion decisions.
module i2s4_ctrl #(
    parameter int W  = 18,
    parameter int CW = 5
) (
    input  logic          sck,
    input  logic          rst_n,
    input  logic          ws,
    output logic          close_o,
    output logic [CW-1:0] cnt_o,
    output logic          take_left_o,
    output logic          take_right_o
);
    import i2s4_pkg::*;

    localparam logic [CW-1:0] LIM = CW'(W);

    typedef struct packed {
        logic          primed;
        side_e         ws_prev;
        logic [CW-1:0] cnt;
        logic          started;
        logic          have_left;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  chg;

    always_comb begin
        st_d         = st_q;
        chg          = st_q.primed && (ws != st_q.ws_prev);
        take_left_o  = chg && (st_q.ws_prev == SIDE_LEFT) && st_q.started;
        take_right_o = chg && (st_q.ws_prev == SIDE_RIGHT) && st_q.started && st_q.have_left;

        st_d.primed  = 1'b1;
        st_d.ws_prev = side_e'(ws);
        if (chg) begin
            st_d.cnt     = '0;
            st_d.started = 1'b1;
        end else if (st_q.cnt != LIM) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (take_left_o)  st_d.have_left = 1'b1;
        if (take_right_o) st_d.have_left = 1'b0;

        close_o = chg;
        cnt_o   = st_q.cnt;
    end

    always_ff @(posedge sck or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/i2s4_xfer.sv
`timescale 1ns/1ps
// Parks a full sample set in the bit-clock domain and hands it over by toggle.
module i2s4_xfer #(
    parameter int W      = 18,
    parameter int SYNC_N = 2
) (
    input  logic         sck,
    input  logic         clk_sys,
    input  logic         rst_n,
    input  logic         take_left_i,
    input  logic         take_right_i,
    input  logic [W-1:0] front_i,
    input  logic [W-1:0] rear_i,
    output logic [4*W-1:0] hold_o,
    output logic         tog_o,
    output logic [4*W-1:0] set_o,
    output logic         valid_o
);
    typedef struct packed {
        logic [W-1:0]   left_f;
        logic [W-1:0]   left_r;
        logic [4*W-1:0] hold;
        logic           tog;
    } park_t;

    typedef struct packed {
        logic [SYNC_N:0] sync;
        logic [4*W-1:0]  set;
        logic            valid;
    } out_t;

    park_t pk_d, pk_q;
    out_t  ot_d, ot_q;

    always_comb begin
        pk_d = pk_q;
        if (take_left_i) begin
            pk_d.left_f = front_i;
            pk_d.left_r = rear_i;
        end
        if (take_right_i) begin
            pk_d.hold = {pk_q.left_f, front_i, pk_q.left_r, rear_i};
            pk_d.tog  = ~pk_q.tog;
        end
    end

    always_ff @(posedge sck or negedge rst_n) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end

    always_comb begin
        ot_d       = ot_q;
        ot_d.sync  = {ot_q.sync[SYNC_N-1:0], pk_q.tog};
        ot_d.valid = ot_q.sync[SYNC_N] ^ ot_q.sync[SYNC_N-1];
        if (ot_d.valid) ot_d.set = pk_q.hold;
    end

    always_ff @(posedge clk_sys or negedge rst_n) begin
        if (!rst_n) ot_q <= '0;
        else        ot_q <= ot_d;
    end

    assign hold_o  = pk_q.hold;
    assign tog_o   = pk_q.tog;
    assign set_o   = ot_q.set;
    assign valid_o = ot_q.valid;
endmodule

// File: rtl/i2s4_rx.sv
`timescale 1ns/1ps
module i2s4_rx #(
    parameter int DATA_W = i2s4_pkg::SAMPLE_W,
    parameter int SYNC_N = i2s4_pkg::SYNC_N
) (
    input  logic              clk_sys,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              ws,
    input  logic              sd_front,
    input  logic              sd_rear,
    output logic              word_valid,
    output logic [DATA_W-1:0] word_fl,
    output logic [DATA_W-1:0] word_fr,
    output logic [DATA_W-1:0] word_rl,
    output logic [DATA_W-1:0] word_rr
);
    localparam int CW    = $clog2(DATA_W + 1);
    localparam int LINES = 2;

    logic              close_w;
    logic [CW-1:0]     cnt_w;
    logic              take_left_w;
    logic              take_right_w;
    logic [DATA_W-1:0] lane_word [LINES];
    logic [LINES-1:0]  lane_sd;
    logic [4*DATA_W-1:0] hold_w;
    logic              tog_w;
    logic [4*DATA_W-1:0] set_w;

    assign lane_sd = {sd_rear, sd_front};

    i2s4_ctrl #(.W(DATA_W), .CW(CW)) u_ctrl (
        .sck          (sck),
        .rst_n        (rst_n),
        .ws           (ws),
        .close_o      (close_w),
        .cnt_o        (cnt_w),
        .take_left_o  (take_left_w),
        .take_right_o (take_right_w)
    );

    for (genvar g = 0; g < LINES; g++) begin : g_lane
        i2s4_lane #(.W(DATA_W), .CW(CW)) u_lane (
            .sck     (sck),
            .rst_n   (rst_n),
            .sd      (lane_sd[g]),
            .close_i (close_w),
            .cnt_i   (cnt_w),
            .word_o  (lane_word[g])
        );
    end

    i2s4_xfer #(.W(DATA_W), .SYNC_N(SYNC_N)) u_xfer (
        .sck          (sck),
        .clk_sys      (clk_sys),
        .rst_n        (rst_n),
        .take_left_i  (take_left_w),
        .take_right_i (take_right_w),
        .front_i      (lane_word[0]),
        .rear_i       (lane_word[1]),
        .hold_o       (hold_w),
        .tog_o        (tog_w),
        .set_o        (set_w),
        .valid_o      (word_valid)
    );

    assign word_fl = set_w[4*DATA_W-1 -: DATA_W];
    assign word_fr = set_w[3*DATA_W-1 -: DATA_W];
    assign word_rl = set_w[2*DATA_W-1 -: DATA_W];
    assign word_rr = set_w[DATA_W-1 -: DATA_W];
endmodule

// File: rtl/i2s4_rx_chk.sv
`timescale 1ns/1ps
module i2s4_rx_chk #(
    parameter int W = 18
) (
    input logic           clk_sys,
    input logic           sck,
    input logic           rst_n,
    input logic           word_valid,
    input logic [4*W-1:0] words,
    input logic [4*W-1:0] hold,
    input logic           tog
);
    // R6: the strobe lasts one system cycle
    a_r6_single_pulse: assert property (@(posedge clk_sys) disable iff (!rst_n)
        word_valid |=> !word_valid);

    // R8: the outputs move only together with the strobe
    a_r8_words_steady: assert property (@(posedge clk_sys) disable iff (!rst_n)
        !word_valid |-> $stable(words));

    // R7: reset leaves zero words and no strobe
    a_r7_reset_clear: assert property (@(posedge clk_sys)
        !rst_n |=> (!word_valid && words == '0));

    // R6: a parked set changes only when its handover toggle flips
    a_r6_update_with_toggle: assert property (@(posedge sck) disable iff (!rst_n)
        !$stable(hold) |-> (tog != $past(tog)));
endmodule

bind i2s4_rx i2s4_rx_chk #(.W(DATA_W)) u_chk (
    .clk_sys    (clk_sys),
    .sck        (sck),
    .rst_n      (rst_n),
    .word_valid (word_valid),
    .words      ({word_fl, word_fr, word_rl, word_rr}),
    .hold       (hold_w),
    .tog        (tog_w)
);

// File: tb/sim_i2s4_rx.sv
`timescale 1ns/1ps
module sim_i2s4_rx;
    localparam int W  = 18;
    localparam int NF = 6;

    logic clk_sys = 1'b0;
    logic sck = 1'b0;
    logic rst_n = 1'b0;
    logic ws = 1'b0;
    logic sd_front = 1'b0;
    logic sd_rear = 1'b0;
    logic word_valid;
    logic [W-1:0] word_fl, word_fr, word_rl, word_rr;

    always #2.5 clk_sys = ~clk_sys;
    always #20  sck = ~sck;

    i2s4_rx u0 (
        .clk_sys, .rst_n, .sck, .ws, .sd_front, .sd_rear,
        .word_valid, .word_fl, .word_fr, .word_rl, .word_rr
    );

    localparam logic [W-1:0] T_FL [NF] = '{18'h20000, 18'h2A5A5, 18'h3C003, 18'h3FFFF, 18'h1DEAD, 18'h00000};
    localparam logic [W-1:0] T_FR [NF] = '{18'h1FFFF, 18'h15A5A, 18'h003C0, 18'h2AAAA, 18'h2BEEF, 18'h3FFFF};
    localparam logic [W-1:0] T_RL [NF] = '{18'h00001, 18'h0F0F0, 18'h12345, 18'h15555, 18'h0CAFE, 18'h20001};
    localparam logic [W-1:0] T_RR [NF] = '{18'h3FFFF, 18'h30F0F, 18'h2BCDE, 18'h0FFFF, 18'h3F00D, 18'h1FFFE};
    localparam int           T_LEN[NF] = '{18, 24, 32, 12, 16, 18};

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic pf = 1'b0, pr = 1'b0;

    int n_got = 0;
    logic [W-1:0] g_fl [16], g_fr [16], g_rl [16], g_rr [16];

    always @(negedge clk_sys) begin
        if (!rst_n) n_got = 0;
        else if (word_valid) begin
            if (n_got < 16) begin
                g_fl[n_got] = word_fl; g_fr[n_got] = word_fr;
                g_rl[n_got] = word_rl; g_rr[n_got] = word_rr;
            end
            n_got = n_got + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] expect_w(input logic [W-1:0] v, input int len);
        logic [W-1:0] m = '1;
        if (len < W) m = m << (W - len);
        return v & m;
    endfunction

    task automatic slot(input logic w, input logic a, input logic b);
        @(negedge sck);
        ws = w; sd_front = a; sd_rear = b;
    endtask

    // slot j carries the pending bit, then bit j becomes pending
    task automatic send_word(input logic w, input logic [W-1:0] vf, input logic [W-1:0] vr, input int len);
        for (int j = 0; j < len; j++) begin
            slot(w, pf, pr);
            pf = (j < W) ? vf[W-1-j] : 1'b1;
            pr = (j < W) ? vr[W-1-j] : j[0];
        end
    endtask

    task automatic send_frame(input int k);
        send_word(1'b0, T_FL[k], T_RL[k], T_LEN[k]);
        send_word(1'b1, T_FR[k], T_RR[k], T_LEN[k]);
    endtask

    task automatic flush;
        slot(1'b0, pf, pr);
        repeat (3) @(posedge sck);
        repeat (12) @(negedge clk_sys);
    endtask

    task automatic check_set(input int i, input int k, input string tag);
        chk({"R1 R2 ", tag, " fl"}, 32'(g_fl[i]), 32'(expect_w(T_FL[k], T_LEN[k])));
        chk({"R1 R2 ", tag, " fr"}, 32'(g_fr[i]), 32'(expect_w(T_FR[k], T_LEN[k])));
        chk({"R1 R2 ", tag, " rl"}, 32'(g_rl[i]), 32'(expect_w(T_RL[k], T_LEN[k])));
        chk({"R1 R2 ", tag, " rr"}, 32'(g_rr[i]), 32'(expect_w(T_RR[k], T_LEN[k])));
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk_sys);
        // R7: reset state
        chk("R7 reset valid", 32'(word_valid), 0);
        chk("R7 reset fl", 32'(word_fl), 0);
        chk("R7 reset fr", 32'(word_fr), 0);
        chk("R7 reset rl", 32'(word_rl), 0);
        chk("R7 reset rr", 32'(word_rr), 0);
        @(negedge sck); rst_n = 1'b1;

        // lead-in right word, then the vector table back to back
        send_word(1'b1, '0, '0, W);
        for (int k = 0; k < NF; k++) send_frame(k);
        flush();
        chk("R6 one strobe per frame", 32'(n_got), NF);
        for (int k = 0; k < NF; k++)
            check_set(k, k, (T_LEN[k] > W) ? "R4" : (T_LEN[k] < W) ? "R5" : "R3");

        // R8: idle stream, outputs hold the last set
        repeat (300) @(negedge clk_sys);
        chk("R8 no strobe when idle", 32'(n_got), NF);
        chk("R8 hold fl", 32'(word_fl), 32'(T_FL[NF-1]));
        chk("R8 hold rr", 32'(word_rr), 32'(T_RR[NF-1]));

        // R7: reset mid-stream clears outputs
        @(negedge clk_sys); rst_n = 1'b0;
        repeat (3) @(negedge clk_sys);
        chk("R7 mid reset valid", 32'(word_valid), 0);
        chk("R7 mid reset fl", 32'(word_fl), 0);
        chk("R7 mid reset rr", 32'(word_rr), 0);
        @(negedge sck); rst_n = 1'b1;

        // R7: stream resumes with a left word in progress; first frame discarded
        send_frame(1);
        send_frame(2);
        flush();
        chk("R7 first frame after reset dropped", 32'(n_got), 1);
        check_set(0, 2, "R7");

        // R6: left word alone produces no strobe
        send_word(1'b0, T_FL[0], T_RL[0], W);
        slot(1'b1, pf, pr);
        repeat (20) @(negedge clk_sys);
        chk("R6 left held until right closes", 32'(n_got), 1);
        chk("R6 outputs unchanged after left", 32'(word_fl), 32'(T_FL[2]));

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule